// File: doc/BRIEF.md
# E1 Transmit Frame Assembler

This block builds the serial E1 basic frame. A host writes the 30 voice or data channel octets over a parallel byte port, each tagged with its channel number 1 to 30. The block also takes a signalling octet, the international or CRC bit, a remote-alarm bit and five spare bits. From these it emits one line bit per clock enable. The enable pulses at the 2.048 Mbit/s line rate, which gives 8000 frames of 256 bits each per second.

Each frame holds 32 eight-bit timeslots. Timeslot 0 carries the overhead word, and timeslot 16 carries the signalling octet. Channels 1 to 15 fill timeslots 1 to 15, and channels 16 to 30 fill timeslots 17 to 31. The overhead word switches between the alignment word and the non-alignment word on every frame. The alignment word is sent first after reset.

Next to the line bit, the block drives a frame-start strobe, a timeslot-start strobe, the current timeslot number and a flag that marks an alignment frame. These let a downstream line coder or monitor follow the frame. CRC generation and line coding sit outside this block.

Top module: `e1_tx_framer`

## Requirements
- R1: While reset is low, line_bit, frame_start, ts_start, ts_idx and fas_frame are all 0. The first frame after reset carries the alignment word, so fas_frame is 1 when its frame_start appears.
- R2: Each frame is 32 timeslots of 8 bits. ts_idx shows the timeslot of the bit on line_bit and counts 0 to 31, then wraps. ts_start is 1 only on the first bit of each timeslot. frame_start is 1 only on the first bit of timeslot 0.
- R3: Outputs change only at a clock edge where bit_en is 1. At any other edge they hold their values.
- R4: Each timeslot octet goes out most significant bit first: bit 7 of the parallel byte first and bit 0 last.
- R5: In an alignment frame, the timeslot 0 octet is {si_bit, 7'b0011011}, written bit 7 down to bit 0.
- R6: In a non-alignment frame, the timeslot 0 octet is {si_bit, 1'b1, rai_bit, sa_bits[4:0]}. Here sa_bits[4] is the fourth-position spare bit, sent first of the five.
- R7: fas_frame is updated at each frame start and holds for the whole frame. It alternates 1, 0, 1, 0 on successive frames without a break.
- R8: Channel n is sent in timeslot n for n from 1 to 15, and in timeslot n+1 for n from 16 to 30.
- R9: Timeslot 16 carries sig_byte as it stands when that timeslot begins.
- R10: A channel octet is captured when its timeslot begins. A write to that channel during the timeslot, or at the same edge as the capture, leaves the octet being sent unchanged and shows up in the next frame.
- R11: A write with wr_chan equal to 0 or to 31 has no effect on any timeslot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Line-rate bit enable |
| wr_en | input | 1 | Channel octet write strobe |
| wr_chan | input | 5 | Channel number of the write (1 to 30) |
| wr_data | input | 8 | Channel octet |
| sig_byte | input | 8 | Signalling octet for timeslot 16 |
| si_bit | input | 1 | International or CRC bit for the first position of timeslot 0 |
| rai_bit | input | 1 | Remote-alarm bit for the non-alignment word |
| sa_bits | input | 5 | Spare bits for the non-alignment word, fourth-position bit in bit 4 |
| line_bit | output | 1 | Serial line bit |
| frame_start | output | 1 | First bit of timeslot 0 is on the line |
| ts_start | output | 1 | First bit of a timeslot is on the line |
| ts_idx | output | 5 | Timeslot of the current line bit |
| fas_frame | output | 1 | Current frame carries the alignment word |

## Verification
Two events can land on the same clock edge: a host write to a channel, and the capture of that channel's octet at the start of its timeslot. The bench sets this up by asserting wr_en for channel 5 at the same edge as the bit_en that begins timeslot 5. It also writes channel 19 in the middle of timeslot 20. In both cases the bench expects the old octet for the rest of the current frame and the new octet in the following frame, with every bit compared against a model of the frame built from its arithmetic layout.

// File: rtl/e1_tx_framer.sv
module e1_tx_framer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       wr_en,
  input  logic [4:0] wr_chan,
  input  logic [7:0] wr_data,
  input  logic [7:0] sig_byte,
  input  logic       si_bit,
  input  logic       rai_bit,
  input  logic [4:0] sa_bits,
  output logic       line_bit,
  output logic       frame_start,
  output logic       ts_start,
  output logic [4:0] ts_idx,
  output logic       fas_frame
);
  localparam int NCH = 30;

  logic [7:0] chan_mem [NCH];
  logic [7:0] pos;
  logic [6:0] shreg;
  logic       fas_next;
  logic [4:0] rd_idx;
  logic [7:0] slot_byte;

  wire [4:0] nts   = pos[7:3];
  wire       first = (pos[2:0] == 3'd0);
  wire [7:0] fas_word  = {si_bit, 7'b0011011};
  wire [7:0] nfas_word = {si_bit, 1'b1, rai_bit, sa_bits};
  wire       wr_ok = wr_en && (wr_chan != 5'd0) && (wr_chan <= 5'(NCH));

  always_comb begin
    rd_idx = (nts > 5'd16) ? nts - 5'd2 : nts - 5'd1;
    if (nts == 5'd0)       slot_byte = fas_next ? fas_word : nfas_word;
    else if (nts == 5'd16) slot_byte = sig_byte;
    else                   slot_byte = chan_mem[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) chan_mem[i] <= '0;
    end else if (wr_ok) begin
      chan_mem[wr_chan - 5'd1] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos         <= '0;
      shreg       <= '0;
      fas_next    <= 1'b1;
      line_bit    <= 1'b0;
      frame_start <= 1'b0;
      ts_start    <= 1'b0;
      ts_idx      <= '0;
      fas_frame   <= 1'b0;
    end else if (bit_en) begin
      pos         <= pos + 8'd1;
      ts_idx      <= nts;
      ts_start    <= first;
      frame_start <= (pos == 8'd0);
      if (first) begin
        line_bit <= slot_byte[7];
        shreg    <= slot_byte[6:0];
        if (nts == 5'd0) begin
          fas_frame <= fas_next;
          fas_next  <= ~fas_next;
        end
      end else begin
        line_bit <= shreg[6];
        shreg    <= {shreg[5:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/e1_tx_framer_chk.sv
module e1_tx_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       line_bit,
  input logic       frame_start,
  input logic       ts_start,
  input logic [4:0] ts_idx,
  input logic       fas_frame
);
  logic       fs_q, ts_q, seen, last_fas;
  logic [4:0] last_ts;

  wire fs_rise = frame_start & ~fs_q;
  wire ts_rise = ts_start & ~ts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q <= 1'b0; ts_q <= 1'b0; seen <= 1'b0; last_fas <= 1'b0; last_ts <= '0;
    end else begin
      fs_q <= frame_start;
      ts_q <= ts_start;
      if (fs_rise) begin seen <= 1'b1; last_fas <= fas_frame; end
      if (ts_rise) last_ts <= ts_idx;
    end
  end

  // R2
  fs_in_ts0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (ts_start && ts_idx == 5'd0));

  // R2
  ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_rise && !frame_start) |-> (ts_idx == 5'(last_ts + 5'd1)));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(line_bit) && $stable(ts_idx) && $stable(frame_start) && $stable(fas_frame)));

  // R1
  first_fas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_rise && !seen) |-> fas_frame);

  // R7
  fas_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_rise && seen) |-> (fas_frame != last_fas));
endmodule

bind e1_tx_framer e1_tx_framer_chk i_chk (.*);

// File: tb/test_e1_tx_framer.sv
module test_e1_tx_framer;
  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, wr_en = 1'b0;
  logic [4:0] wr_chan = '0;
  logic [7:0] wr_data = '0, sig_byte = '0;
  logic si_bit = 1'b0, rai_bit = 1'b0;
  logic [4:0] sa_bits = '0;
  logic line_bit, frame_start, ts_start, fas_frame;
  logic [4:0] ts_idx;

  e1_tx_framer i_e1_tx_framer (.*);

  always #10 clk = ~clk;

  int errors = 0, checks = 0, fc = 0;
  bit done = 1'b0;
  logic [7:0] mdl [1:30];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (frame %0d)", req, act, exp, fc);
    end
  endtask

  task automatic wr(input int ch, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_chan = 5'(ch); wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    if (ch >= 1 && ch <= 30) mdl[ch] = d;
  endtask

  function automatic logic [7:0] exp_byte(input int t);
    if (t == 0) return (fc % 2 == 0) ? {si_bit, 7'b0011011} : {si_bit, 1'b1, rai_bit, sa_bits};
    if (t == 16) return sig_byte;
    return mdl[(t < 16) ? t : t - 1];
  endfunction

  task automatic run_frames(input int n, input bit events);
    for (int f = 0; f < n; f++) begin
      for (int t = 0; t < 32; t++) begin
        logic [7:0] cur;
        cur = exp_byte(t);
        for (int k = 0; k < 8; k++) begin
          int ech;
          logic lb, fs, tss, ff;
          logic [4:0] ti;
          ech = -1;
          @(negedge clk); bit_en = 1'b1;
          if (events && f == 0 && t == 5 && k == 0) begin ech = 5; wr_data = 8'hE7; end
          if (events && f == 0 && t == 20 && k == 3) begin ech = 19; wr_data = 8'h18; end
          if (events && f == 1 && t == 0 && k == 2) begin ech = 0; wr_data = 8'hFF; end
          if (events && f == 1 && t == 1 && k == 2) begin ech = 31; wr_data = 8'hFF; end
          if (ech >= 0) begin wr_en = 1'b1; wr_chan = 5'(ech); end
          @(negedge clk); bit_en = 1'b0; wr_en = 1'b0;
          if (ech >= 1 && ech <= 30) mdl[ech] = wr_data;
          // R4 R5 R6 R8 R9 R10 R11: serial bit against the modelled octet
          chk(line_bit == cur[7-k], $sformatf("R4/R8/R10 ts%0d bit%0d", t, k), int'(line_bit), int'(cur[7-k]));
          chk(ts_idx == 5'(t), "R2 ts_idx", int'(ts_idx), t);
          chk(ts_start == (k == 0), "R2 ts_start", int'(ts_start), int'(k == 0));
          chk(frame_start == (t == 0 && k == 0), "R2 frame_start", int'(frame_start), int'(t == 0 && k == 0));
          if (t == 0 && k == 0)
            chk(fas_frame == (fc % 2 == 0), "R7 fas_frame phase", int'(fas_frame), int'(fc % 2 == 0));
          lb = line_bit; fs = frame_start; tss = ts_start; ti = ts_idx; ff = fas_frame;
          @(negedge clk);
          chk(line_bit == lb && frame_start == fs && ts_start == tss && ts_idx == ti && fas_frame == ff,
              "R3 hold without bit_en", int'({line_bit, frame_start, ts_idx}), int'({lb, fs, ti}));
        end
      end
      fc++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({line_bit, frame_start, ts_start, ts_idx, fas_frame} == '0, "R1 reset outputs",
        int'({line_bit, frame_start, ts_start, ts_idx, fas_frame}), 0);
    rst_n = 1'b1;
    for (int c = 1; c <= 30; c++) wr(c, 8'(c * 37 + 11));
    si_bit = 1'b1; rai_bit = 1'b0; sa_bits = 5'b10110; sig_byte = 8'hA5;
    run_frames(2, 1'b0);
    for (int c = 1; c <= 30; c++) wr(c, 8'(c * 91 ^ 8'h5A));
    si_bit = 1'b0; rai_bit = 1'b1; sa_bits = 5'b01001; sig_byte = 8'h3C;
    run_frames(2, 1'b1);
    run_frames(1, 1'b0);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule